// File: doc/BRIEF.md
# I/O Flag Skip Unit

This unit sits beside the instruction decoder of an 18-bit processor. When an I/O-transfer instruction is executed, it issues a device-select pulse carrying the device code. If the instruction is a flag test, it also tells the sequencer whether to skip the next instruction. The skip depends on one ready flag, chosen from a vector of device flags by the instruction's device code. The test counts only when it is issued at event time 1 of the I/O cycle.

A second instruction, the status read, packs the interrupt-enable state, the six base device flags, the clock-enabled state and the tape-interrupt state into an accumulator image. The processor then merges that image into its accumulator.

The flag vector holds fourteen inputs by default. It grows in groups of seven through a parameter. All outputs are registered and appear one clock after the execute strobe.

Top module: `iot_flag_skip_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is driven to 0 on that edge, whatever `exec` does.
- R2: Bit 17 of `instr` is instruction bit 0. The fields are: opcode `instr[17:12]` (I/O transfer when it equals octal 70), device `instr[11:6]`, subdevice `instr[5:4]` and pulse select `instr[3:0]`. An executed I/O transfer gives `dev_pulse`=1 and `dev_code`=device on the next cycle. Any other opcode gives `dev_pulse`=0 and `dev_code`=0.
- R3: A flag test has subdevice 0 and pulse select 0001. It requests a skip when its flag is 1. The base map is: device 00 clock overflow (flag 0), 01 reader (1), 02 punch (2), 03 keyboard (3), 04 printer (4), 05 display (5).
- R4: Devices octal 64, 65, 66 and 67 test flags 6 (card punch ready), 7 (line printer ready), 8 (line printer spacing) and 9 (card reader full).
- R5: A flag test whose selected flag is 0 gives `skip_req`=0.
- R6: `evt_time` encodes event time 1 as value 1. A flag test issued with any other `evt_time` value gives `skip_req`=0.
- R7: A device code with no flag attached never skips. Nor does an I/O transfer with any other subdevice or pulse-select value.
- R8: Flag k, for k of 10 and above, is tested by device octal 10 + (k − 10). The flag count is 14 + 7·`N_EXP`.
- R9: Octal 700314 is the status read, accepted at any event time. On the next cycle it gives `status_valid`=1 and a `status_word` in which instruction bit n is `status_word[17-n]`. The bits are: 0 interrupt enable, 1 reader, 2 punch, 3 keyboard, 4 printer, 5 display, 6 clock overflow, 7 clock enabled, 8 tape interrupt.
- R10: Instruction bits 9–17 of the status word are 0, and `status_word` is 0 whenever `status_valid` is 0.
- R11: Each output responds exactly one cycle after a single-cycle `exec` and returns to 0 on the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 18 | Instruction word |
| exec | input | 1 | Execute strobe, one cycle per instruction |
| evt_time | input | 2 | Current event time of the I/O cycle |
| flags | input | 14+7·N_EXP | Device ready flags |
| int_en | input | 1 | Interrupt-enable state for the status read |
| clk_en | input | 1 | Clock-enabled state for the status read |
| tape_int | input | 1 | Tape interrupt state for the status read |
| skip_req | output | 1 | Skip the next instruction |
| dev_pulse | output | 1 | Device-select pulse |
| dev_code | output | 6 | Device code accompanying the pulse |
| status_valid | output | 1 | Status image valid |
| status_word | output | 18 | Packed status image |

## Verification
On every cycle, the assertions check several implications against the inputs of the previous cycle:
- a skip request implies an executed flag-test encoding at event time 1 with at least one flag set;
- a device pulse implies an executed I/O opcode, and carries that cycle's device field;
- skip and status never coincide;
- the unassigned status bits, and the whole word outside a valid cycle, stay zero.

Only the bench's sweeps show which device code reaches which flag, the exact bit placement in the status image, and the refusal to skip for every unmapped code and every other pulse field.

// File: rtl/iot_skip_pkg.sv
// Package: shared field layout, code constants and flag-to-device map
// for the I/O flag skip unit. Assumes instruction bit 0 is vector bit 17.
package iot_skip_pkg;

    localparam logic [5:0] IOT_OPCODE = 6'o70;
    localparam logic [1:0] SUB_TEST   = 2'b00;
    localparam logic [3:0] PSEL_TEST  = 4'b0001;
    localparam logic [5:0] DEV_STATUS = 6'o03;
    localparam logic [5:0] LOW_STATUS = 6'o14;
    localparam logic [1:0] EVT_TEST   = 2'd1;

    localparam int BASE_FLAGS  = 14;
    localparam int GROUP_FLAGS = 7;
    localparam int NAMED_FLAGS = 10;

    // Instruction word split into its fields, most significant first.
    typedef struct packed {
        logic [5:0] opcode;
        logic [5:0] device;
        logic [1:0] subdev;
        logic [3:0] psel;
    } iot_word_t;

    // Device code that tests flag k.
    function automatic logic [5:0] flag_device(input int k);
        if (k < 6)
            return 6'(k);
        else if (k < NAMED_FLAGS)
            return 6'o64 + 6'(k - 6);
        else
            return 6'o10 + 6'(k - NAMED_FLAGS);
    endfunction

endpackage

// File: rtl/iot_field_decode.sv
// Field decoder: splits the instruction word and classifies it as an
// I/O transfer, a flag test or a status read. Purely combinational.
module iot_field_decode
    import iot_skip_pkg::*;
(
    input  logic [17:0] word,
    output logic [5:0]  device,
    output logic        is_iot,
    output logic        is_test,
    output logic        is_status
);

    iot_word_t w;

    assign w = iot_word_t'(word);

    // Classify the word by opcode, subdevice and pulse select.
    always_comb begin
        device    = w.device;
        is_iot    = (w.opcode == IOT_OPCODE);
        is_test   = is_iot && (w.subdev == SUB_TEST) && (w.psel == PSEL_TEST);
        is_status = is_iot && (w.device == DEV_STATUS) && ({w.subdev, w.psel} == LOW_STATUS);
    end

endmodule

// File: rtl/iot_flag_map.sv
// Flag selector: compares the device code against the fixed code of every
// flag input and returns the selected flag. An unmapped code selects nothing.
module iot_flag_map
    import iot_skip_pkg::*;
#(
    parameter int NFLAG = 14
) (
    input  logic [5:0]       device,
    input  logic [NFLAG-1:0] flags,
    output logic             sel_flag
);

    logic [NFLAG-1:0] hit;

    // One comparator per flag input.
    for (genvar k = 0; k < NFLAG; k++) begin : g_cmp
        assign hit[k] = (device == flag_device(k));
    end

    assign sel_flag = |(hit & flags);

endmodule

// File: rtl/iot_status_pack.sv
// Status packer: places the status sources into the accumulator image.
// Instruction bit n sits at vector bit 17-n; unassigned bits are zero.
module iot_status_pack (
    input  logic        int_en,
    input  logic        clk_en,
    input  logic        tape_int,
    input  logic [5:0]  base_flags,
    output logic [17:0] image
);

    localparam int B_IE   = 17;
    localparam int B_RDR  = 16;
    localparam int B_PUN  = 15;
    localparam int B_KBD  = 14;
    localparam int B_PRT  = 13;
    localparam int B_DSP  = 12;
    localparam int B_OVF  = 11;
    localparam int B_CEN  = 10;
    localparam int B_TAPE = 9;

    // Build the image bit by bit.
    always_comb begin
        image         = '0;
        image[B_IE]   = int_en;
        image[B_RDR]  = base_flags[1];
        image[B_PUN]  = base_flags[2];
        image[B_KBD]  = base_flags[3];
        image[B_PRT]  = base_flags[4];
        image[B_DSP]  = base_flags[5];
        image[B_OVF]  = base_flags[0];
        image[B_CEN]  = clk_en;
        image[B_TAPE] = tape_int;
    end

endmodule

// File: rtl/iot_flag_skip_unit.sv
// Top: I/O flag skip unit. Registers the device pulse, the skip request and
// the status image one cycle after exec. Assumes exec is a one-cycle strobe
// per executed instruction and that flags are stable around it.
module iot_flag_skip_unit
    import iot_skip_pkg::*;
#(
    parameter  int N_EXP = 0,
    localparam int NFLAG = BASE_FLAGS + GROUP_FLAGS * N_EXP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [17:0]      instr,
    input  logic             exec,
    input  logic [1:0]       evt_time,
    input  logic [NFLAG-1:0] flags,
    input  logic             int_en,
    input  logic             clk_en,
    input  logic             tape_int,
    output logic             skip_req,
    output logic             dev_pulse,
    output logic [5:0]       dev_code,
    output logic             status_valid,
    output logic [17:0]      status_word
);

    logic [5:0]  device;
    logic        is_iot;
    logic        is_test;
    logic        is_status;
    logic        sel_flag;
    logic [17:0] image;

    iot_field_decode u_dec (
        .word      (instr),
        .device    (device),
        .is_iot    (is_iot),
        .is_test   (is_test),
        .is_status (is_status)
    );

    iot_flag_map #(.NFLAG(NFLAG)) u_map (
        .device   (device),
        .flags    (flags),
        .sel_flag (sel_flag)
    );

    iot_status_pack u_pack (
        .int_en     (int_en),
        .clk_en     (clk_en),
        .tape_int   (tape_int),
        .base_flags (flags[5:0]),
        .image      (image)
    );

    // Register all outputs one cycle after the execute strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            skip_req     <= 1'b0;
            dev_pulse    <= 1'b0;
            dev_code     <= '0;
            status_valid <= 1'b0;
            status_word  <= '0;
        end else begin
            dev_pulse    <= exec && is_iot;
            dev_code     <= (exec && is_iot) ? device : 6'd0;
            skip_req     <= exec && is_test && (evt_time == EVT_TEST) && sel_flag;
            status_valid <= exec && is_status;
            status_word  <= (exec && is_status) ? image : 18'd0;
        end
    end

    p_skip_evt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        skip_req |-> ($past(exec) && $past(evt_time) == EVT_TEST));

    p_skip_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        skip_req |-> ($past(instr[17:12]) == 6'o70 && $past(instr[5:0]) == 6'o01));

    p_skip_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        skip_req |-> $past(|flags));

    p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dev_pulse |-> ($past(exec) && $past(instr[17:12]) == 6'o70
                       && dev_code == $past(instr[11:6])));

    p_skip_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        skip_req |-> dev_pulse);

    p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(skip_req && status_valid));

    p_stat_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[8:0] == 9'd0) && (status_valid || status_word == 18'd0));

    p_stat_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        status_valid |-> ($past(exec) && $past(instr) == 18'o700314));

endmodule

// File: tb/iot_flag_skip_unit_tb.sv
module iot_flag_skip_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] instr = '0;
    logic        exec = 1'b0;
    logic [1:0]  evt_time = '0;
    logic [13:0] flags = '0;
    logic        int_en = 1'b0;
    logic        clk_en = 1'b0;
    logic        tape_int = 1'b0;
    logic        skip_req;
    logic        dev_pulse;
    logic [5:0]  dev_code;
    logic        status_valid;
    logic [17:0] status_word;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    iot_flag_skip_unit u_dut (
        .clk(clk), .rst_n(rst_n), .instr(instr), .exec(exec),
        .evt_time(evt_time), .flags(flags), .int_en(int_en),
        .clk_en(clk_en), .tape_int(tape_int), .skip_req(skip_req),
        .dev_pulse(dev_pulse), .dev_code(dev_code),
        .status_valid(status_valid), .status_word(status_word)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Device code that tests flag k (R3, R4, R8).
    function automatic int code_of(input int k);
        if (k < 6) return k;
        if (k < 10) return 52 + (k - 6);
        return 8 + (k - 10);
    endfunction

    function automatic int idx_of(input int dev);
        for (int k = 0; k < 14; k++)
            if (code_of(k) == dev) return k;
        return -1;
    endfunction

    task automatic issue(input logic [17:0] w, input logic [1:0] et, input logic [13:0] fl);
        @(negedge clk);
        instr = w; evt_time = et; flags = fl; exec = 1'b1;
        @(negedge clk);
        exec = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset holds outputs low even with a strobe
        instr = 18'o700101; evt_time = 2'd1; flags = '1; exec = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 skip", skip_req, 0);
        chk("R1 pulse", dev_pulse, 0);
        chk("R1 status", status_valid, 0);
        chk("R1 word", status_word, 0);
        exec = 1'b0;
        @(negedge clk); rst_n = 1'b1;

        // R3 R4 R5 R6 R7 R8: every device code, both flag polarities, all event times
        for (int d = 0; d < 64; d++)
            for (int p = 0; p < 2; p++)
                for (int e = 0; e < 4; e++) begin
                    issue({6'o70, 6'(d), 6'o01}, 2'(e), p ? 14'h3fff : 14'h0);
                    chk("R3/R4/R5/R6/R7/R8 skip", skip_req,
                        (e == 1 && p == 1 && idx_of(d) >= 0) ? 1 : 0);
                    chk("R2 pulse", dev_pulse, 1);
                    chk("R2 code", dev_code, d);
                end

        // R8 R7: one flag at a time, only its own device skips
        for (int k = 0; k < 14; k++)
            for (int j = 0; j < 14; j++) begin
                issue({6'o70, 6'(code_of(j)), 6'o01}, 2'd1, 14'(1 << k));
                chk("R8 one-hot select", skip_req, (j == k) ? 1 : 0);
            end

        // R7: other subdevice / pulse fields never skip
        for (int lo = 0; lo < 64; lo++) begin
            issue({6'o70, 6'o01, 6'(lo)}, 2'd1, 14'h3fff);
            chk("R7 pulse field", skip_req, (lo == 1) ? 1 : 0);
        end

        // R2: non-I/O opcode gives no pulse and zero code
        issue(18'o600101, 2'd1, 14'h3fff);
        chk("R2 non-iot pulse", dev_pulse, 0);
        chk("R2 non-iot code", dev_code, 0);
        chk("R2 non-iot skip", skip_req, 0);

        // R11: outputs drop the cycle after
        issue(18'o700101, 2'd1, 14'h3fff);
        chk("R11 skip on", skip_req, 1);
        @(negedge clk);
        chk("R11 skip off", skip_req, 0);
        chk("R11 pulse off", dev_pulse, 0);

        // R9 R10: status read image
        for (int i = 0; i < 32; i++) begin
            logic [13:0] fl;
            logic [17:0] exp;
            fl = 14'((i * 14'h1357) ^ (i << 5));
            int_en = i[0]; clk_en = i[1]; tape_int = i[2];
            issue(18'o700314, 2'(i), fl);
            exp = {int_en, fl[1], fl[2], fl[3], fl[4], fl[5], fl[0], clk_en, tape_int, 9'd0};
            chk("R9 status valid", status_valid, 1);
            chk("R9 status word", status_word, exp);
            chk("R10 low bits", status_word[8:0], 0);
            chk("R7 no skip on status", skip_req, 0);
            @(negedge clk);
            chk("R10 word cleared", status_word, 0);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule